// File: doc/BRIEF.md
# ADC Burst Sequencer and Accumulator

This block is the digital controller that sits beside a 10-bit successive-approximation converter core. After a start strobe it runs a burst of conversions. Before each conversion it drives a track command for a programmed number of clocks, then issues a one-cycle start command. It then waits for the core's done handshake and adds the returned 10-bit code into an accumulator. When the last conversion of the burst has been added, the sum appears as a right-justified 16-bit word and a done flag pulses.

Three modes are supported:

- **Normal:** plain 10-bit conversions.
- **Reduced:** the core is told to stop after eight bit decisions, and the two lowest code bits are discarded.
- **Enhanced:** each group of four conversions is taken at reference sub-steps 0, 1, 2 and 3 and summed into one higher-resolution sample. In this mode a track-once control decides whether the input is tracked only before the first conversion of each group, or before every conversion.

The configuration is captured when a burst is accepted. Everything arriving while a burst runs is ignored.

Top module: `adc_burst_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, track_o, conv_start_o, done_o and short_conv_o are 0, substep_o is 0 and result_o is 0.
- R2: An accepted burst holds track_o high for track_len_i clocks (a value of 0 counts as 1) before a conversion. The track phase is followed directly by a conv_start_o pulse exactly one clock wide.
- R3: The number of conversions in a burst follows rpt_sel_i: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 32, and 5, 6 or 7 give 64.
- R4: result_o equals the sum of the accepted codes of the burst, right-justified. It appears together with done_o in the cycle after the final conv_done_i and holds until the next burst completes.
- R5: The accumulator starts from zero for every burst, so no earlier burst contributes to a result.
- R6: mode_i = 01 selects reduced mode. In this mode short_conv_o is 1 for the whole burst and bits 1:0 of every code are taken as 00. In all other modes short_conv_o is 0.
- R7: mode_i = 10 selects enhanced mode, where substep_o at each conv_start_o pulse is the conversion index modulo 4 (0, 1, 2, 3, 0, ...). In modes 00, 01 and 11 (11 behaves as 00) substep_o is 0.
- R8: In enhanced mode an rpt_sel_i of 0 runs 4 conversions instead of 1. Four full-scale codes (1023) give 4092.
- R9: In enhanced mode with track_once_i = 1, only the first conversion of each group of four is preceded by a track phase; the others start one clock after the previous done, with no track phase. With track_once_i = 0, or outside enhanced mode, every conversion has a track phase.
- R10: A start_i strobe, or any change of the configuration inputs, while a burst runs has no effect on that burst and does not launch another.
- R11: done_o is a single-cycle pulse.
- R12: An enhanced burst of 16 full-scale codes gives 16368.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst start strobe |
| mode_i | input | 2 | 00 normal, 01 reduced, 10 enhanced, 11 as normal |
| track_once_i | input | 1 | Enhanced mode: track once per group of four |
| rpt_sel_i | input | 3 | Repeat count select |
| track_len_i | input | 4 | Track phase length in clocks (0 taken as 1) |
| conv_done_i | input | 1 | Core finished a conversion |
| conv_code_i | input | 10 | Code from the core, valid with conv_done_i |
| track_o | output | 1 | Track the input |
| conv_start_o | output | 1 | Start one conversion |
| short_conv_o | output | 1 | Stop after eight bit decisions |
| substep_o | output | 2 | Reference sub-step index |
| result_o | output | 16 | Accumulated result |
| done_o | output | 1 | Burst complete pulse |

## Verification
The conversion index is the state most likely to go wrong, and its errors show up at the ports at once. A wrong index gives a substep_o value off the 0-3 rotation at the very next conv_start_o pulse. It also gives a conversion count that differs at the done pulse, and a track phase present or missing where the track-once rule says otherwise. A fault in the accumulator or in the code mask shows only when done_o pulses, as a result_o that differs from the sum the bench builds from the codes it returned. The bench therefore checks every start pulse and every completion across all modes, repeat selects and track lengths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_10B = 2'd0,
    MODE_8B  = 2'd1,
    MODE_ENH = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRACK  = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_WAIT   = 2'd3
  } st_e;

  typedef struct packed {
    logic enh;
    logic short8;
    logic once;
  } cfg_t;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int RPT_W   = 3,
  parameter int MAX_LOG = 6,
  parameter int TRK_W   = 4,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic             once_i,
  input  logic [RPT_W-1:0] rpt_sel_i,
  input  logic [TRK_W-1:0] trk_len_i,
  output cfg_t             cfg_o,
  output logic [CNT_W-1:0] count_o,
  output logic [TRK_W-1:0] trk_len_o
);

  cfg_t             cfg_d;
  logic [CNT_W-1:0] cnt_d;
  logic [TRK_W-1:0] trk_d;

  // Repeat select to conversion count; enhanced never runs fewer than four.
  function automatic logic [CNT_W-1:0] count_of(input logic [RPT_W-1:0] sel,
                                                input logic enh);
    int sh;
    if (sel == '0) return enh ? CNT_W'(4) : CNT_W'(1);
    sh = int'(sel) + 1;
    if (sh > MAX_LOG) sh = MAX_LOG;
    return CNT_W'(1) << sh;
  endfunction

  always_comb begin
    cfg_d.enh    = (mode_e'(mode_i) == MODE_ENH);
    cfg_d.short8 = (mode_e'(mode_i) == MODE_8B);
    cfg_d.once   = once_i & cfg_d.enh;
    cnt_d        = count_of(rpt_sel_i, cfg_d.enh);
    trk_d        = (trk_len_i == '0) ? TRK_W'(1) : trk_len_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o     <= '0;
      count_o   <= CNT_W'(1);
      trk_len_o <= TRK_W'(1);
    end else if (load_i) begin
      cfg_o     <= cfg_d;
      count_o   <= cnt_d;
      trk_len_o <= trk_d;
    end
  end

  // R10: configuration is frozen between accepted starts
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(count_o) && $stable(cfg_o) && $stable(trk_len_o)));

  // R8: an enhanced burst always spans whole groups of four
  a_r8_enh_groups: assert property (@(posedge clk) disable iff (rst)
    cfg_o.enh |-> (count_o >= CNT_W'(4) && count_o[1:0] == 2'b00));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int TRK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  cfg_t             cfg_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [TRK_W-1:0] trk_len_i,
  input  logic             conv_done_i,
  output logic             load_o,
  output logic             add_o,
  output logic             last_o,
  output logic             track_o,
  output logic             conv_start_o,
  output logic             short_o,
  output logic [1:0]       substep_o,
  output logic             done_o
);

  st_e              st_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] idx_nx;
  logic [TRK_W-1:0] tcnt_q;
  logic             done_q;
  logic             is_last;

  assign idx_nx  = idx_q + CNT_W'(1);
  assign is_last = (idx_q == count_i - CNT_W'(1));
  assign load_o  = (st_q == ST_IDLE) && start_i;
  assign add_o   = (st_q == ST_WAIT) && conv_done_i;
  assign last_o  = add_o && is_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      tcnt_q <= TRK_W'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_TRACK;
            idx_q  <= '0;
            tcnt_q <= TRK_W'(1);
          end
        end
        ST_TRACK: begin
          if (tcnt_q >= trk_len_i) st_q <= ST_LAUNCH;
          else                     tcnt_q <= tcnt_q + TRK_W'(1);
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (conv_done_i) begin
            if (is_last) begin
              st_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_nx;
              tcnt_q <= TRK_W'(1);
              // held sample: skip tracking inside a group of four
              if (cfg_i.once && idx_nx[1:0] != 2'b00) st_q <= ST_LAUNCH;
              else                                    st_q <= ST_TRACK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // outputs decode the state flops directly
  assign track_o      = (st_q == ST_TRACK);
  assign conv_start_o = (st_q == ST_LAUNCH);
  assign short_o      = cfg_i.short8 && (st_q != ST_IDLE);
  assign substep_o    = cfg_i.enh ? idx_q[1:0] : 2'b00;
  assign done_o       = done_q;

  // R2: start command is one clock wide
  a_r2_launch_single: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  // R2: a track phase always ends in a start command
  a_r2_track_then_launch: assert property (@(posedge clk) disable iff (rst)
    $fell(track_o) |-> conv_start_o);

  // R11: done is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: first conversion of each group is preceded by tracking
  a_r9_group_tracked: assert property (@(posedge clk) disable iff (rst)
    (conv_start_o && substep_o == 2'd0) |-> $past(track_o));

  // R3: index never runs past the programmed count
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> (idx_q < count_i));

  // R10: a start during a burst does not end or restart it
  a_r10_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    ((st_q != ST_IDLE) && start_i && !last_o) |=> (st_q != ST_IDLE && !load_o));

endmodule

// File: rtl/adc_seq_acc.sv
module adc_seq_acc #(
  parameter int CODE_W = 10,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic              last_i,
  input  logic              short_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [RES_W-1:0]  result_o
);

  logic [RES_W-1:0]  acc_q;
  logic [RES_W-1:0]  res_q;
  logic [CODE_W-1:0] code_m;
  logic [RES_W-1:0]  sum;

  assign code_m   = short_i ? {code_i[CODE_W-1:2], 2'b00} : code_i;
  assign sum      = acc_q + RES_W'(code_m);
  assign result_o = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (clr_i)      acc_q <= '0;
      else if (add_i) acc_q <= sum;
      if (add_i && last_i) res_q <= sum;
    end
  end

  // R4: result only moves on the final addition
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !(add_i && last_i) |=> $stable(result_o));

  // R5: every burst begins from an empty accumulator
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (acc_q == '0));

  // R6: reduced mode never contributes the two low bits
  a_r6_low_bits: assert property (@(posedge clk) disable iff (rst)
    (short_i && add_i) |=> (acc_q[1:0] == 2'b00));

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_seq_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int RES_W   = 16,
  parameter int RPT_W   = 3,
  parameter int MAX_LOG = 6,
  parameter int TRK_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              track_once_i,
  input  logic [RPT_W-1:0]  rpt_sel_i,
  input  logic [TRK_W-1:0]  track_len_i,
  input  logic              conv_done_i,
  input  logic [CODE_W-1:0] conv_code_i,
  output logic              track_o,
  output logic              conv_start_o,
  output logic              short_conv_o,
  output logic [1:0]        substep_o,
  output logic [RES_W-1:0]  result_o,
  output logic              done_o
);

  localparam int CNT_W = MAX_LOG + 1;

  cfg_t             cfg;
  logic [CNT_W-1:0] count;
  logic [TRK_W-1:0] trk_len;
  logic             load, add, last;

  adc_seq_cfg #(
    .RPT_W(RPT_W), .MAX_LOG(MAX_LOG), .TRK_W(TRK_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load_i(load), .mode_i(mode_i),
    .once_i(track_once_i), .rpt_sel_i(rpt_sel_i), .trk_len_i(track_len_i),
    .cfg_o(cfg), .count_o(count), .trk_len_o(trk_len)
  );

  adc_seq_fsm #(
    .CNT_W(CNT_W), .TRK_W(TRK_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg), .count_i(count),
    .trk_len_i(trk_len), .conv_done_i(conv_done_i), .load_o(load),
    .add_o(add), .last_o(last), .track_o(track_o),
    .conv_start_o(conv_start_o), .short_o(short_conv_o),
    .substep_o(substep_o), .done_o(done_o)
  );

  adc_seq_acc #(
    .CODE_W(CODE_W), .RES_W(RES_W)
  ) u_acc (
    .clk(clk), .rst(rst), .clr_i(load), .add_i(add), .last_i(last),
    .short_i(short_conv_o), .code_i(conv_code_i), .result_o(result_o)
  );

endmodule

// File: tb/adc_burst_seq_test.sv
`timescale 1ns/1ps
module adc_burst_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        track_once_i = 1'b0;
  logic [2:0]  rpt_sel_i = 3'd0;
  logic [3:0]  track_len_i = 4'd1;
  logic        conv_done_i = 1'b0;
  logic [9:0]  conv_code_i = 10'd0;
  logic        track_o, conv_start_o, short_conv_o, done_o;
  logic [1:0]  substep_o;
  logic [15:0] result_o;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  adc_burst_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .track_once_i(track_once_i), .rpt_sel_i(rpt_sel_i),
    .track_len_i(track_len_i), .conv_done_i(conv_done_i),
    .conv_code_i(conv_code_i), .track_o(track_o),
    .conv_start_o(conv_start_o), .short_conv_o(short_conv_o),
    .substep_o(substep_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int md, input int sel);
    int sh;
    if (sel == 0) return (md == 2) ? 4 : 1;
    sh = sel + 1;
    if (sh > 6) sh = 6;
    return 1 << sh;
  endfunction

  // pat: 0 random codes, 1 full scale, 2 zero
  task automatic run_burst(input int md, input bit once, input int sel,
                           input int tlen, input int pat, input bit poke);
    int n, teff, k, trk, pend, sum, guard, exp_trk, held;
    bit enh, fin;
    logic [9:0] code;
    n = exp_count(md, sel);
    teff = (tlen == 0) ? 1 : tlen;
    enh = (md == 2);
    k = 0; trk = 0; pend = -1; sum = 0; guard = 0; fin = 0; code = '0;
    @(negedge clk);
    mode_i = 2'(md); track_once_i = once; rpt_sel_i = 3'(sel);
    track_len_i = 4'(tlen); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      mode_i = 2'(md ^ 1); track_once_i = ~once;
      rpt_sel_i = 3'(sel ^ 3); track_len_i = 4'(tlen ^ 5);
    end
    while (!fin && guard < 6000) begin
      conv_done_i = 1'b0;
      start_i = 1'b0;
      if (track_o) trk++;
      if (conv_start_o) begin
        exp_trk = (!enh || !once || (k % 4) == 0) ? teff : 0;
        chk(trk == exp_trk, once ? "R9 track phase" : "R2 track length", trk, exp_trk);
        chk(substep_o == 2'((enh ? k % 4 : 0)), "R7 substep", substep_o, enh ? k % 4 : 0);
        chk(short_conv_o == (md == 1), "R6 short flag", short_conv_o, md == 1);
        trk = 0;
        pend = $urandom_range(1, 3);
        code = (pat == 1) ? 10'h3FF : (pat == 2) ? 10'h000 : 10'($urandom);
        if (poke && k == 1) start_i = 1'b1;
        k++;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          conv_done_i = 1'b1;
          conv_code_i = code;
          sum += (md == 1) ? int'(code & 10'h3FC) : int'(code);
          pend = -1;
        end
      end
      if (done_o) begin
        chk(k == n, "R3 conversion count", k, n);
        chk(result_o == 16'(sum), "R4 result sum", result_o, sum);
        fin = 1;
        held = result_o;
      end
      @(negedge clk);
      guard++;
    end
    conv_done_i = 1'b0;
    start_i = 1'b0;
    chk(fin, "R4 burst completed", fin, 1);
    chk(done_o == 1'b0, "R11 done width", done_o, 0);
    chk(result_o == 16'(held), "R4 result hold", result_o, held);
    if (poke) begin
      for (int i = 0; i < 4; i++) begin
        chk(!track_o && !conv_start_o, "R10 no relaunch", track_o, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!track_o && !conv_start_o && !done_o && !short_conv_o, "R1 reset outputs",
        {track_o, conv_start_o, done_o, short_conv_o}, 0);
    chk(result_o == 16'd0 && substep_o == 2'd0, "R1 reset result", result_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!track_o && !done_o && result_o == 16'd0, "R1 after reset", result_o, 0);

    run_burst(0, 0, 0, 0, 0, 0);           // R2 zero length as one
    run_burst(1, 0, 1, 3, 0, 0);           // R6 reduced, 4 conversions
    run_burst(2, 1, 0, 2, 1, 0);           // R8 enhanced count 1 -> 4
    chk(result_o == 16'd4092, "R8 enhanced full scale", result_o, 4092);
    run_burst(2, 0, 0, 0, 2, 0);
    chk(result_o == 16'd0, "R5 accumulator cleared", result_o, 0);
    run_burst(2, 1, 3, 4, 1, 0);
    chk(result_o == 16'd16368, "R12 sixteen full scale", result_o, 16368);
    run_burst(2, 0, 2, 1, 0, 0);           // R9 track every conversion
    run_burst(3, 1, 7, 15, 0, 0);          // R7 mode 11 as normal, 64
    run_burst(0, 0, 5, 1, 1, 0);
    chk(result_o == 16'd65472, "R3 sixty-four full scale", result_o, 65472);
    run_burst(2, 1, 2, 3, 0, 1);           // R10 pokes during burst
    run_burst(1, 0, 0, 6, 0, 1);

    for (int b = 0; b < 30; b++) begin
      run_burst(int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 1)) == 1 ? 0 : 1,
                1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule